// File: doc/BRIEF.md
# Page-Splitting Translated Transfer Sequencer

This block takes one transfer request made in virtual addresses (start address, byte count, direction) and walks it as a series of chunks, none of which straddles a 4096-byte page. For every chunk it asks an external translator for the physical address of the chunk's first byte. It then issues one physical memory burst command that carries that address, the chunk length and the direction.

Each chunk is translated on its own, so a range that is contiguous in virtual space may land on scattered physical pages. Only one chunk is outstanding at any time. The translator and the memory port both use valid/ready handshakes, and the translator answers with a separate one-cycle response. The block signals the end of a transfer with a one-cycle completion pulse. An error flag accompanies that pulse when a translation fault cut the transfer short.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, req_ready is 1, xl_valid, mem_valid and done are 0.
- R2: Each chunk length is the smaller of the remaining byte count and 4096 minus bits [11:0] of the chunk's virtual address, so no chunk crosses a 4096-byte boundary and no chunk is empty.
- R3: The first translation request carries the start address, and each later one carries the previous chunk's address plus the previous chunk's length.
- R4: A memory command follows a non-faulting translation response in the next cycle, with mem_paddr equal to the returned address, mem_len equal to the chunk length and mem_write equal to the request's write bit (1 = write, 0 = read).
- R5: Only one chunk is in flight: xl_valid and mem_valid are never high together, and the next translation is not requested before the memory command is accepted.
- R6: done is a one-cycle pulse, with error 0, in the cycle after the handshake of the last chunk's memory command.
- R7: A faulting translation response (xl_resp_fault = 1) suppresses that chunk's memory command and every later chunk, for reads and writes alike, and done pulses with error 1 in the next cycle.
- R8: A request with a byte count of 0 pulses done with error 0 in the cycle after acceptance, with no translation request and no memory command.
- R9: req_ready is 1 only while idle, and a request presented while busy is ignored and does not change the chunks of the transfer in progress.
- R10: A raised xl_valid or mem_valid stays high with a stable address and length until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | VA_W | Virtual start address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| xl_valid | output | 1 | Translation request valid |
| xl_ready | input | 1 | Translator accepts the request |
| xl_vaddr | output | VA_W | Virtual address to translate |
| xl_resp_valid | input | 1 | Translation response present (one cycle) |
| xl_resp_paddr | input | PA_W | Physical address returned |
| xl_resp_fault | input | 1 | Translation failed |
| mem_valid | output | 1 | Memory burst command valid |
| mem_ready | input | 1 | Memory accepts the command |
| mem_paddr | output | PA_W | Physical burst address |
| mem_len | output | PAGE_BITS+1 | Burst length in bytes |
| mem_write | output | 1 | Burst direction, 1 = write |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Set with done when a fault aborted the transfer |

## Verification
Every result has a fixed latency: a translation request appears the cycle after acceptance or after the previous memory handshake, a memory command the cycle after a clean translation response, and done the cycle after the final memory handshake, the fault response, or the zero-length acceptance. The bench drives inputs and samples outputs on the falling edge. It remembers whether the preceding falling edge set up a final handshake or a fault, and it requires done at exactly the next falling edge and its absence one edge later. Ready stalls move those edges but not the one-cycle offsets, which the bench tracks per cycle rather than by fixed waits.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XREQ  = 2'd1,
    ST_XWAIT = 2'd2,
    ST_MCMD  = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/chunk_calc.sv
`timescale 1ns/1ps
module chunk_calc #(
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 16,
  localparam int CH_W     = PAGE_BITS + 1
) (
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic [LEN_W-1:0]     remain,
  output logic [CH_W-1:0]      chunk
);
  localparam logic [CH_W-1:0] PAGE_BYTES = CH_W'(1) << PAGE_BITS;

  logic [CH_W-1:0]  room;
  logic [LEN_W-1:0] room_ext;

  always_comb begin
    room     = PAGE_BYTES - {1'b0, page_off};
    room_ext = LEN_W'(room);
    chunk    = (remain < room_ext) ? remain[CH_W-1:0] : room;
  end
endmodule

// File: rtl/xfer_cursor.sv
`timescale 1ns/1ps
module xfer_cursor #(
  parameter int VA_W  = 32,
  parameter int LEN_W = 16,
  parameter int CH_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VA_W-1:0]  load_va,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  input  logic [CH_W-1:0]  step_len,
  output logic [VA_W-1:0]  cur_va,
  output logic [LEN_W-1:0] cur_remain,
  output logic             is_last
);
  logic [VA_W-1:0]  va_q;
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      va_q  <= load_va;
      rem_q <= load_len;
    end else if (step) begin
      va_q  <= va_q + VA_W'(step_len);
      rem_q <= rem_q - LEN_W'(step_len);
    end
  end

  assign cur_va     = va_q;
  assign cur_remain = rem_q;
  assign is_last    = (rem_q == LEN_W'(step_len));
endmodule

// File: rtl/xfer_splitter.sv
`timescale 1ns/1ps
module xfer_splitter
  import xfer_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 40,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 12,
  localparam int CH_W     = PAGE_BITS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             xl_valid,
  input  logic             xl_ready,
  output logic [VA_W-1:0]  xl_vaddr,
  input  logic             xl_resp_valid,
  input  logic [PA_W-1:0]  xl_resp_paddr,
  input  logic             xl_resp_fault,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [PA_W-1:0]  mem_paddr,
  output logic [CH_W-1:0]  mem_len,
  output logic             mem_write,
  output logic             done,
  output logic             error
);
  xfer_state_t      state_q;
  logic [PA_W-1:0]  paddr_q;
  logic             wr_q;
  logic             done_q;
  logic             err_q;

  logic [VA_W-1:0]  cur_va;
  logic [LEN_W-1:0] cur_rem;
  logic [CH_W-1:0]  chunk;
  logic             is_last;
  logic             accept;
  logic             load;
  logic             mem_hs;

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign load   = accept && (req_len != '0);
  assign mem_hs = (state_q == ST_MCMD) && mem_ready;

  xfer_cursor #(.VA_W(VA_W), .LEN_W(LEN_W), .CH_W(CH_W)) u_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_va   (req_vaddr),
    .load_len  (req_len),
    .step      (mem_hs),
    .step_len  (chunk),
    .cur_va    (cur_va),
    .cur_remain(cur_rem),
    .is_last   (is_last)
  );

  chunk_calc #(.PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)) u_calc (
    .page_off(cur_va[PAGE_BITS-1:0]),
    .remain  (cur_rem),
    .chunk   (chunk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      paddr_q <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wr_q <= req_write;
            if (req_len == '0) done_q  <= 1'b1;
            else               state_q <= ST_XREQ;
          end
        end
        ST_XREQ: begin
          if (xl_ready) state_q <= ST_XWAIT;
        end
        ST_XWAIT: begin
          if (xl_resp_valid) begin
            if (xl_resp_fault) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              paddr_q <= xl_resp_paddr;
              state_q <= ST_MCMD;
            end
          end
        end
        ST_MCMD: begin
          if (mem_ready) begin
            if (is_last) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_XREQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign xl_valid  = (state_q == ST_XREQ);
  assign xl_vaddr  = cur_va;
  assign mem_valid = (state_q == ST_MCMD);
  assign mem_paddr = paddr_q;
  assign mem_len   = chunk;
  assign mem_write = wr_q;
  assign done      = done_q;
  assign error     = err_q;
endmodule

// File: rtl/xfer_splitter_chk.sv
`timescale 1ns/1ps
module xfer_splitter_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 12,
  localparam int CH_W     = PAGE_BITS + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            xl_valid,
  input logic            xl_ready,
  input logic [VA_W-1:0] xl_vaddr,
  input logic            xl_resp_valid,
  input logic [PA_W-1:0] xl_resp_paddr,
  input logic            xl_resp_fault,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_paddr,
  input logic [CH_W-1:0] mem_len,
  input logic            done,
  input logic            error
);
  localparam logic [CH_W:0] PAGE_BYTES = (CH_W+1)'(1) << PAGE_BITS;

  logic                 pend;
  logic [PAGE_BITS-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      off_q <= '0;
    end else if (xl_valid && xl_ready) begin
      pend  <= 1'b1;
      off_q <= xl_vaddr[PAGE_BITS-1:0];
    end else if (xl_resp_valid) begin
      pend  <= 1'b0;
    end
  end

  a_r5_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    !(xl_valid && mem_valid));

  a_r10_xl_hold: assert property (@(posedge clk) disable iff (rst)
    xl_valid && !xl_ready |=> xl_valid && $stable(xl_vaddr));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_paddr) && $stable(mem_len));

  a_r2_no_cross: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_len != '0) &&
                  (({1'b0, 1'b0, off_q} + {1'b0, mem_len}) <= PAGE_BYTES));

  a_r4_mem_follows: assert property (@(posedge clk) disable iff (rst)
    pend && xl_resp_valid && !xl_resp_fault |=> mem_valid && (mem_paddr == $past(xl_resp_paddr)));

  a_r7_fault_abort: assert property (@(posedge clk) disable iff (rst)
    pend && xl_resp_valid && xl_resp_fault |=> done && error && !mem_valid && !xl_valid);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready && !xl_valid && !mem_valid);
endmodule

bind xfer_splitter xfer_splitter_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .xl_valid     (xl_valid),
  .xl_ready     (xl_ready),
  .xl_vaddr     (xl_vaddr),
  .xl_resp_valid(xl_resp_valid),
  .xl_resp_paddr(xl_resp_paddr),
  .xl_resp_fault(xl_resp_fault),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_paddr    (mem_paddr),
  .mem_len      (mem_len),
  .done         (done),
  .error        (error)
);

// File: tb/xfer_splitter_test.sv
`timescale 1ns/1ps
module xfer_splitter_test;
  localparam int VA_W = 32;
  localparam int PA_W = 40;
  localparam int LEN_W = 16;
  localparam int PAGE_BITS = 12;
  localparam int CH_W = PAGE_BITS + 1;
  localparam int MAXC = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_write = 1'b0;
  logic xl_valid;
  logic xl_ready = 1'b0;
  logic [VA_W-1:0] xl_vaddr;
  logic xl_resp_valid = 1'b0;
  logic [PA_W-1:0] xl_resp_paddr = '0;
  logic xl_resp_fault = 1'b0;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [PA_W-1:0] mem_paddr;
  logic [CH_W-1:0] mem_len;
  logic mem_write;
  logic done;
  logic error;

  int checks = 0;
  int errors = 0;

  logic [VA_W-1:0] got_xva [MAXC];
  logic [PA_W-1:0] got_mpa [MAXC];
  logic [CH_W-1:0] got_mlen [MAXC];
  logic            got_mwr [MAXC];
  int n_xl;
  int n_mem;

  always #5 clk = ~clk;

  xfer_splitter #(.VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_len(req_len), .req_write(req_write),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_vaddr(xl_vaddr),
    .xl_resp_valid(xl_resp_valid), .xl_resp_paddr(xl_resp_paddr),
    .xl_resp_fault(xl_resp_fault),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_paddr(mem_paddr),
    .mem_len(mem_len), .mem_write(mem_write),
    .done(done), .error(error)
  );

  function automatic logic [PA_W-1:0] tr(input logic [VA_W-1:0] v);
    tr = {8'hA5, v[31:12] ^ 20'h13579, v[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(xl_valid == 1'b0, "R1", "xl_valid after reset", xl_valid, 0);
    chk(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  // Runs one transfer acting as translator and memory; fault_at < 0 means no fault.
  task automatic run_xfer(input string name, input logic [VA_W-1:0] va,
                          input logic [LEN_W-1:0] len, input bit wr,
                          input int fault_at, input bit stall, input bit intrude);
    int cyc = 0;
    bit finished = 0;
    bit resp_next = 0;
    bit prev_mem_hs = 0;
    bit prev_fault = 0;
    bit overlap = 0;
    bit intruded = 0;
    bit busy_ready_seen = 0;
    bit got_err = 0;
    bit exp_err;
    logic [VA_W-1:0] va_e;
    logic [LEN_W-1:0] rem_e;
    logic [CH_W-1:0] c_e;
    int nch;
    int exp_xl;
    int exp_mem;
    n_xl = 0;
    n_mem = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", {name, " idle ready"}, req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_len = len; req_write = wr;
    while (!finished && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      req_valid = 1'b0;
      xl_resp_valid = 1'b0;
      xl_resp_fault = 1'b0;
      if (done) begin
        finished = 1;
        got_err = error;
        if (fault_at >= 0)
          chk(prev_fault, "R7", {name, " done one cycle after fault"}, prev_fault, 1);
        else
          chk(prev_mem_hs, "R6", {name, " done one cycle after last burst"}, prev_mem_hs, 1);
      end else begin
        if (resp_next) begin
          xl_resp_valid = 1'b1;
          xl_resp_paddr = tr(got_xva[n_xl-1]);
          xl_resp_fault = (fault_at == n_xl - 1);
          resp_next = 0;
          if (intrude && !intruded) begin
            intruded = 1;
            req_valid = 1'b1; req_vaddr = 32'hDEAD_0000; req_len = 16'h0040; req_write = ~wr;
            if (req_ready) busy_ready_seen = 1;
          end
        end
        if (xl_valid && mem_valid) overlap = 1;
        xl_ready = stall ? (cyc % 3 != 0) : 1'b1;
        mem_ready = stall ? (cyc % 4 != 1) : 1'b1;
        if (xl_valid && xl_ready && n_xl < MAXC) begin
          got_xva[n_xl] = xl_vaddr;
          n_xl++;
          resp_next = 1;
        end
        prev_mem_hs = 0;
        if (mem_valid && mem_ready && n_mem < MAXC) begin
          got_mpa[n_mem] = mem_paddr;
          got_mlen[n_mem] = mem_len;
          got_mwr[n_mem] = mem_write;
          n_mem++;
          prev_mem_hs = 1;
        end
        prev_fault = xl_resp_valid && xl_resp_fault;
      end
    end
    req_valid = 1'b0; xl_ready = 1'b0; mem_ready = 1'b0;
    xl_resp_valid = 1'b0; xl_resp_fault = 1'b0;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 %s watchdog: no done actual=0 expected=1", name);
      return;
    end
    @(negedge clk);
    chk(done == 1'b0, "R6", {name, " done is one cycle"}, done, 0);
    exp_err = (fault_at >= 0);
    chk(got_err == exp_err, exp_err ? "R7" : "R6", {name, " error flag"}, got_err, exp_err);
    chk(!overlap, "R5", {name, " xl and mem never together"}, overlap, 0);
    if (intrude)
      chk(!busy_ready_seen, "R9", {name, " req_ready low while busy"}, busy_ready_seen, 0);
    // expected chunking from the requirements
    va_e = va; rem_e = len; nch = 0;
    while (rem_e != 0) begin
      c_e = ((4096 - va_e[11:0]) < rem_e) ? CH_W'(4096 - va_e[11:0]) : CH_W'(rem_e);
      if (nch < n_xl)
        chk(got_xva[nch] == va_e, "R3", {name, " xlate vaddr"}, got_xva[nch], va_e);
      if (nch < n_mem) begin
        chk(got_mlen[nch] == c_e, "R2", {name, " chunk length"}, got_mlen[nch], c_e);
        chk(got_mpa[nch] == tr(va_e), "R4", {name, " burst paddr"}, got_mpa[nch], tr(va_e));
        chk(got_mwr[nch] == wr, "R4", {name, " burst direction"}, got_mwr[nch], wr);
      end
      va_e = va_e + VA_W'(c_e);
      rem_e = rem_e - LEN_W'(c_e);
      nch++;
    end
    exp_xl = (fault_at >= 0) ? fault_at + 1 : nch;
    exp_mem = (fault_at >= 0) ? fault_at : nch;
    chk(n_xl == exp_xl, (fault_at >= 0) ? "R7" : "R5", {name, " translation count"}, n_xl, exp_xl);
    chk(n_mem == exp_mem, (fault_at >= 0) ? "R7" : "R2", {name, " burst count"}, n_mem, exp_mem);
    @(negedge clk);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h4000_0123; req_len = '0; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R8", "zero length done next cycle", done, 1);
    chk(error == 1'b0, "R8", "zero length no error", error, 0);
    chk(!xl_valid && !mem_valid, "R8", "zero length no commands", {xl_valid, mem_valid}, 0);
    @(negedge clk);
    chk(done == 1'b0 && !xl_valid && !mem_valid, "R8", "zero length quiet after",
        {done, xl_valid, mem_valid}, 0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_xfer("single", 32'h1000_0010, 16'd100, 1'b0, -1, 1'b0, 1'b0);
    run_xfer("cross", 32'h2000_0FF0, 16'h0030, 1'b1, -1, 1'b0, 1'b0);
    run_xfer("multi_stall_intrude", 32'h3000_0800, 16'h2000, 1'b0, -1, 1'b1, 1'b1);
    run_xfer("aligned_page", 32'h5000_0000, 16'h1000, 1'b1, -1, 1'b0, 1'b0);
    run_xfer("last_byte", 32'h6000_0FFF, 16'd1, 1'b0, -1, 1'b0, 1'b0);
    run_xfer("two_bytes_split", 32'h6000_1FFF, 16'd2, 1'b1, -1, 1'b1, 1'b0);
    run_xfer("fault_write_mid", 32'h7000_0F00, 16'h1200, 1'b1, 1, 1'b0, 1'b0);
    run_xfer("fault_read_first", 32'h8000_0000, 16'h0100, 1'b0, 0, 1'b1, 1'b0);
    t_zero_len();
    run_xfer("after_fault", 32'h9000_0FFC, 16'h0008, 1'b0, -1, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule